// File: doc/BRIEF.md
# Proportional and Digital Channel Frame Unpacker

The block turns one already-validated 25-byte radio-control frame into eighteen 11-bit channel values and two status flags. Bytes 1 to 22 of the frame carry sixteen proportional channels. These are packed end to end, least significant bit first, so a field may start or end in the middle of a byte. Byte 23 carries two on/off channels and two status bits. The bytes at offsets 0 and 24 are framing bytes and play no part in decoding.

A one-cycle `start` pulse while the block is idle does two things: it samples the frame presented on `frame_in`, and it begins a sequential pass. The pass uses a bit accumulator. In each cycle it either merges the next frame byte into the accumulator or emits one 11-bit channel from it. Each channel appears once on a valid/index/data stream. Once all eighteen channels have been streamed, `done` pulses. In that same cycle the complete set of channel values and both flags become visible together on the parallel outputs. Those outputs never show a frame that is only partly decoded.

Top module: `chan_unpacker`

## Requirements
- R1: After reset, `busy`, `done` and `ch_valid` are 0, and `ch_all`, `lost_frame` and `failsafe` are all 0.
- R2: Byte i of the frame occupies bits 8i+7..8i of `frame_in`. Proportional channel k (k = 0..15) equals bits 8+11k+10 .. 8+11k of `frame_in`, with the lower bit as the channel LSB. In `ch_all`, channel k occupies bits 11k+10..11k.
- R3: Each pass emits exactly eighteen `ch_valid` beats. Their `ch_index` values are 0, 1, ..., 17 in ascending order. The `ch_data` of each beat equals that channel's final value.
- R4: Channel 16 follows bit 0 of byte 23 (`frame_in` bit 184), and channel 17 follows bit 1 (bit 185). Each is 2047 when its bit is 1 and 0 when its bit is 0.
- R5: `lost_frame` takes bit 2 of byte 23 (bit 186), and `failsafe` takes bit 3 (bit 187).
- R6: `done` is a single-cycle pulse. It comes one cycle after the last beat. `ch_all`, `lost_frame` and `failsafe` change only in a cycle where `done` is 1.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running pass completes with its original stream and results, and no second pass follows from it.
- R8: The frame is sampled in the cycle in which `start` is accepted. Changes to `frame_in` during a pass have no effect on that pass.
- R9: The reference frame 0F 03 04 E0 3E 00 08 0F 78 C0 E3 E1 00 7C 38 00 01 08 40 00 02 10 80 00 00 decodes to channels 1027, 1024, 251, 1024, 240, 240, 240, 1807, 1024, 1807, 1024, 1024, 1024, 1024, 1024, 1024, 0, 0.
- R10: `busy` rises in the cycle after an accepted `start`. It is 0 in the cycle in which `done` is 1, and `ch_valid` is only ever 1 while `busy` is 1.
- R11: Bytes 0 and 24, and bits 4..7 of byte 23, have no influence on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass; sampled only while idle |
| frame_in | input | 200 | Frame bytes, byte i at bits 8i+7..8i |
| busy | output | 1 | A pass is in progress |
| ch_valid | output | 1 | A channel beat is on `ch_index`/`ch_data` |
| ch_index | output | 5 | Channel number of the beat, 0..17 |
| ch_data | output | 11 | Channel value of the beat |
| done | output | 1 | Pass complete; parallel outputs updated this cycle |
| ch_all | output | 198 | All channels, channel k at bits 11k+10..11k |
| lost_frame | output | 1 | Lost-frame status of the last completed frame |
| failsafe | output | 1 | Failsafe status of the last completed frame |

## Verification
The assertions rely on two properties of the inputs. First, `start` is a pulse from a controller that waits for the block to go idle or tolerates its being ignored. Second, reset is held for at least one clock before any checking begins. With those in place, the beat index counter in the checker can restart only on `done`. The stimulus drives the inputs half a cycle away from the active edge. It holds `start` high for several cycles in the middle of a pass, and changes `frame_in` at the same time, so the ignore rule and the sampling rule are both exercised. It then releases `start` well before the pass ends, so that no unintended second pass begins.

// File: rtl/chunpack_pkg.sv
package chunpack_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 25;
    localparam int CH_W        = 11;
    localparam int NUM_PROP    = 16;
    localparam int NUM_DIG     = 2;
    localparam int NUM_CH      = NUM_PROP + NUM_DIG;
    localparam int DATA_BYTE0  = 1;
    localparam int FLAG_BYTE   = 23;
    localparam int LOST_BIT    = 2;
    localparam int FSAFE_BIT   = 3;
    localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
    localparam int ACC_W       = CH_W + BYTE_W - 1;
    localparam int CNT_W       = $clog2(ACC_W + 1);
    localparam int IDX_W       = $clog2(NUM_CH);
    localparam int PTR_W       = $clog2(FRAME_BYTES);

    typedef enum logic [1:0] {PH_IDLE, PH_PROP, PH_DIG, PH_FIN} phase_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [CH_W-1:0]  data;
    } chan_beat_t;

    function automatic logic [CH_W-1:0] flag_to_chan(input logic b);
        return b ? {CH_W{1'b1}} : {CH_W{1'b0}};
    endfunction
endpackage

// File: rtl/unpack_acc.sv
module unpack_acc
    import chunpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              merge,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CH_W-1:0]   field,
    output logic              ready
);
    logic [ACC_W-1:0] acc;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
            cnt <= '0;
        end else if (merge) begin
            acc <= acc | (ACC_W'(byte_in) << cnt);
            cnt <= cnt + CNT_W'(BYTE_W);
        end else if (take) begin
            acc <= acc >> CH_W;
            cnt <= cnt - CNT_W'(CH_W);
        end
    end

    assign field = acc[CH_W-1:0];
    assign ready = (cnt >= CNT_W'(CH_W));
endmodule

// File: rtl/unpack_seq.sv
module unpack_seq
    import chunpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ready,
    input  logic [CH_W-1:0]   field,
    input  logic [BYTE_W-1:0] flag_byte,
    output logic              capture,
    output logic              merge,
    output logic              take,
    output logic [PTR_W-1:0]  byte_ptr,
    output chan_beat_t        beat,
    output logic              commit,
    output logic              done,
    output logic              busy
);
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] dsel;
    logic [BYTE_W-1:0] fsh;

    assign capture = start && (phase == PH_IDLE);
    assign merge   = (phase == PH_PROP) && !ready;
    assign take    = (phase == PH_PROP) && ready;
    assign commit  = (phase == PH_FIN);
    assign busy    = (phase != PH_IDLE);
    assign dsel    = idx - IDX_W'(NUM_PROP);
    assign fsh     = flag_byte >> dsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            idx      <= '0;
            byte_ptr <= '0;
            beat     <= '0;
            done     <= 1'b0;
        end else begin
            beat.valid <= 1'b0;
            done       <= 1'b0;
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase    <= PH_PROP;
                    idx      <= '0;
                    byte_ptr <= PTR_W'(DATA_BYTE0);
                end
                PH_PROP: if (ready) begin
                    beat <= '{valid: 1'b1, idx: idx, data: field};
                    idx  <= idx + 1'b1;
                    if (idx == IDX_W'(NUM_PROP - 1)) phase <= PH_DIG;
                end else begin
                    byte_ptr <= byte_ptr + 1'b1;
                end
                PH_DIG: begin
                    beat <= '{valid: 1'b1, idx: idx, data: flag_to_chan(fsh[0])};
                    idx  <= idx + 1'b1;
                    if (idx == IDX_W'(NUM_CH - 1)) phase <= PH_FIN;
                end
                PH_FIN: begin
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/unpack_bank.sv
module unpack_bank
    import chunpack_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  chan_beat_t             beat,
    input  logic                   commit,
    input  logic                   lost_in,
    input  logic                   fsafe_in,
    output logic [NUM_CH*CH_W-1:0] ch_all,
    output logic                   lost_frame,
    output logic                   failsafe
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [CH_W-1:0] shadow;
        logic [CH_W-1:0] nxt;
        logic            hit;

        assign hit = beat.valid && (beat.idx == IDX_W'(g));
        assign nxt = hit ? beat.data : shadow;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow                   <= '0;
                ch_all[g*CH_W +: CH_W]   <= '0;
            end else begin
                shadow <= nxt;
                if (commit) ch_all[g*CH_W +: CH_W] <= nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lost_frame <= 1'b0;
            failsafe   <= 1'b0;
        end else if (commit) begin
            lost_frame <= lost_in;
            failsafe   <= fsafe_in;
        end
    end
endmodule

// File: rtl/chan_unpacker.sv
module chan_unpacker
    import chunpack_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [FRAME_W-1:0]     frame_in,
    output logic                   busy,
    output logic                   ch_valid,
    output logic [IDX_W-1:0]       ch_index,
    output logic [CH_W-1:0]        ch_data,
    output logic                   done,
    output logic [NUM_CH*CH_W-1:0] ch_all,
    output logic                   lost_frame,
    output logic                   failsafe
);
    logic [FRAME_W-1:0] frame_q;
    logic               capture, merge, take, ready, commit;
    logic [PTR_W-1:0]   byte_ptr;
    logic [CH_W-1:0]    field;
    logic [BYTE_W-1:0]  cur_byte;
    logic [BYTE_W-1:0]  flag_byte;
    chan_beat_t         beat;

    always_ff @(posedge clk) begin
        if (rst)          frame_q <= '0;
        else if (capture) frame_q <= frame_in;
    end

    assign cur_byte  = frame_q[BYTE_W*byte_ptr +: BYTE_W];
    assign flag_byte = frame_q[BYTE_W*FLAG_BYTE +: BYTE_W];

    unpack_acc u_acc (
        .clk(clk), .rst(rst), .clear(capture), .merge(merge), .take(take),
        .byte_in(cur_byte), .field(field), .ready(ready)
    );

    unpack_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .ready(ready), .field(field),
        .flag_byte(flag_byte), .capture(capture), .merge(merge), .take(take),
        .byte_ptr(byte_ptr), .beat(beat), .commit(commit), .done(done), .busy(busy)
    );

    unpack_bank u_bank (
        .clk(clk), .rst(rst), .beat(beat), .commit(commit),
        .lost_in(flag_byte[LOST_BIT]), .fsafe_in(flag_byte[FSAFE_BIT]),
        .ch_all(ch_all), .lost_frame(lost_frame), .failsafe(failsafe)
    );

    assign ch_valid = beat.valid;
    assign ch_index = beat.idx;
    assign ch_data  = beat.data;
endmodule

// File: rtl/unpack_chk.sv
module unpack_chk
    import chunpack_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   busy,
    input logic                   ch_valid,
    input logic [IDX_W-1:0]       ch_index,
    input logic [CH_W-1:0]        ch_data,
    input logic                   done,
    input logic [NUM_CH*CH_W-1:0] ch_all,
    input logic                   lost_frame,
    input logic                   failsafe
);
    logic             seen;
    logic [IDX_W-1:0] exp_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen    <= 1'b0;
            exp_idx <= '0;
        end else begin
            seen <= 1'b1;
            if (done)          exp_idx <= '0;
            else if (ch_valid) exp_idx <= exp_idx + 1'b1;
        end
    end

    p_beat_order_r3: assert property (@(posedge clk) disable iff (rst)
        ch_valid |-> (ch_index == exp_idx) && (ch_index < IDX_W'(NUM_CH)));

    p_dig_full_scale_r4: assert property (@(posedge clk) disable iff (rst)
        (ch_valid && ch_index >= IDX_W'(NUM_PROP)) |->
            (ch_data == '0 || ch_data == {CH_W{1'b1}}));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        (ch_valid && ch_index == IDX_W'(NUM_CH - 1)) |=> done);

    p_bank_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (seen && !done) |-> $stable(ch_all));

    p_flags_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (seen && !done) |-> ($stable(lost_frame) && $stable(failsafe)));

    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_idle_on_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_beat_in_pass_r10: assert property (@(posedge clk) disable iff (rst)
        ch_valid |-> busy);
endmodule

bind chan_unpacker unpack_chk u_chk (.*);

// File: tb/chan_unpacker_test.sv
module chan_unpacker_test;
    import chunpack_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   start = 1'b0;
    logic [FRAME_W-1:0]     frame_in = '0;
    logic                   busy, ch_valid, done, lost_frame, failsafe;
    logic [IDX_W-1:0]       ch_index;
    logic [CH_W-1:0]        ch_data;
    logic [NUM_CH*CH_W-1:0] ch_all;

    int checks = 0;
    int fails  = 0;
    int stab_err = 0;
    logic [IDX_W+CH_W-1:0] sb_q[$];
    logic [CH_W-1:0]       exp_ch [NUM_CH];
    logic                  exp_lost, exp_fs;
    logic [NUM_CH*CH_W-1:0] prev_all;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_unpacker uut (
        .clk(clk), .rst(rst), .start(start), .frame_in(frame_in), .busy(busy),
        .ch_valid(ch_valid), .ch_index(ch_index), .ch_data(ch_data), .done(done),
        .ch_all(ch_all), .lost_frame(lost_frame), .failsafe(failsafe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model: channel k is bits 8+11k.. of the frame; digital from byte 23
    task automatic load_expect(input logic [FRAME_W-1:0] f);
        for (int k = 0; k < NUM_PROP; k++) begin
            exp_ch[k] = f[8 + 11*k +: 11];
            sb_q.push_back({IDX_W'(k), exp_ch[k]});
        end
        for (int k = 0; k < NUM_DIG; k++) begin
            exp_ch[NUM_PROP+k] = f[184 + k] ? 11'd2047 : 11'd0;
            sb_q.push_back({IDX_W'(NUM_PROP + k), exp_ch[NUM_PROP+k]});
        end
        exp_lost = f[186];
        exp_fs   = f[187];
    endtask

    // Monitor: pops scoreboard on each beat (R3), watches bank stability (R6)
    always @(negedge clk) begin
        if (!rst) begin
            if (ch_valid) begin
                if (sb_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R3 actual=beat %0d expected=no beat", ch_index);
                end else begin
                    logic [IDX_W+CH_W-1:0] e;
                    e = sb_q.pop_front();
                    check("R3 beat", {ch_index, ch_data}, e);
                end
            end
            if (!done && ch_all !== prev_all) stab_err++;
        end
        prev_all = ch_all;
    end

    task automatic run_frame(input logic [FRAME_W-1:0] f, input bit disturb, input string tag);
        int n;
        load_expect(f);
        @(negedge clk);
        frame_in = f;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", busy, 1);
        if (disturb) begin
            // R7/R8: restart attempts with a different frame mid-pass
            frame_in = ~f;
            start    = 1'b1;
            repeat (5) @(negedge clk);
            start    = 1'b0;
        end
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check("R6 done seen", done, 1);
        check("R10 idle at done", busy, 0);
        check("R3 all beats consumed", sb_q.size(), 0);
        for (int k = 0; k < NUM_CH; k++)
            check(k < NUM_PROP ? {tag, " R2 channel"} : {tag, " R4 digital"},
                  ch_all[k*CH_W +: CH_W], exp_ch[k]);
        check({tag, " R5 lost"}, lost_frame, exp_lost);
        check({tag, " R5 failsafe"}, failsafe, exp_fs);
        @(negedge clk);
        check("R6 done pulse", done, 0);
        if (disturb) begin
            repeat (3) @(negedge clk);
            check("R7 no second pass", busy, 0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [FRAME_W-1:0] f, g;
        logic [7:0] refb [FRAME_BYTES] = '{8'h0F, 8'h03, 8'h04, 8'hE0, 8'h3E, 8'h00, 8'h08,
            8'h0F, 8'h78, 8'hC0, 8'hE3, 8'hE1, 8'h00, 8'h7C, 8'h38, 8'h00, 8'h01, 8'h08,
            8'h40, 8'h00, 8'h02, 8'h10, 8'h80, 8'h00, 8'h00};
        int refv [NUM_CH] = '{1027, 1024, 251, 1024, 240, 240, 240, 1807, 1024, 1807,
            1024, 1024, 1024, 1024, 1024, 1024, 0, 0};

        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 valid", ch_valid, 0);
        check("R1 bank", |ch_all, 0);
        check("R1 flags", {lost_frame, failsafe}, 0);
        rst = 1'b0;

        // R9 reference frame
        for (int i = 0; i < FRAME_BYTES; i++) f[8*i +: 8] = refb[i];
        run_frame(f, 0, "ref");
        for (int k = 0; k < NUM_CH; k++) check("R9 reference", ch_all[k*CH_W +: CH_W], refv[k]);

        // all ones: every channel full scale, both flags set
        run_frame('1, 0, "ones");
        // alternating patterns
        for (int i = 0; i < FRAME_BYTES; i++) f[8*i +: 8] = (i % 2) ? 8'hAA : 8'h55;
        run_frame(f, 0, "alt");
        // walking single bits across the data area
        for (int w = 0; w < 4; w++) begin
            f = '0;
            f[8 + 47*w] = 1'b1;
            f[184 + w]  = 1'b1;
            run_frame(f, 0, "walk");
        end
        // R7/R8: start and frame changes ignored mid-pass
        for (int i = 0; i < FRAME_BYTES; i++) f[8*i +: 8] = 8'(i * 37 + 11);
        run_frame(f, 1, "R7 R8 busy-start");

        // R11: framing bytes and upper flag bits do not matter
        for (int i = 0; i < FRAME_BYTES; i++) f[8*i +: 8] = 8'($urandom);
        run_frame(f, 0, "rand");
        g = f;
        g[7:0]     = ~f[7:0];
        g[199:192] = ~f[199:192];
        g[191:188] = ~f[191:188];
        run_frame(g, 0, "R11 framing");

        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < FRAME_BYTES; i++) f[8*i +: 8] = 8'($urandom);
            run_frame(f, r == 1, "rand");
        end

        check("R6 bank stable outside done", stab_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule